// File: doc/BRIEF.md
# Mode-Selectable Array Multiplier

This block is a purely combinational multiplier. It is built as a triangular array of adder rows. Each row forms one partial product by gating the multiplicand with a single multiplier bit. It then adds that partial product into the running sum from the row above, placed one bit position higher than the previous row's addend. The product has as many bits as the two operands together, so no result is ever truncated.

A single mode pin decides how the multiplicand is read. When the pin is low, the multiplicand is an unsigned integer and the upper bits of each partial product are filled with zeros. When the pin is high, the multiplicand is a two's-complement integer and each partial product is sign-extended to the full product width before it is added. In both modes the multiplier operand is unsigned. The same adder rows therefore serve both number systems without a correction step. The default multiplicand width is 5 bits, so that values such as −14 fit, and the multiplier is 4 bits wide, which gives a 9-bit product.

Top module: `mularr_top`

## Requirements
- R1: With `signed_mode` = 0, `product` equals the unsigned value of `mul_a` times the unsigned value of `mul_b` (for example 14 × 11 = 154).
- R2: With `signed_mode` = 1, `mul_a` is read as two's complement (range −16..15 at default width) and `product` is the two's-complement encoding of the true product (for example −14 × 11 = −154, which is 0x166 in 9 bits).
- R3: `mul_b` is treated as unsigned in both modes, so `mul_b` = 15 multiplies by +15 even when its top bit is set.
- R4: `mul_b` = 0 gives `product` = 0 in both modes for every `mul_a`.
- R5: `mul_b` = 1 gives `mul_a` zero-extended to the product width in unsigned mode and sign-extended to the product width in signed mode.
- R6: `mul_b` = 2^k gives `mul_a`, extended according to the mode, shifted left by k positions.
- R7: In signed mode, the top bit of `product` is 1 exactly when `mul_a` is negative and `mul_b` is non-zero.
- R8: The extreme operands are represented without wrap-around: 31 × 15 = 465 in unsigned mode, and −16 × 15 = −240 (0x110) in signed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | MW (5) | Multiplicand; unsigned or two's complement depending on `signed_mode` |
| mul_b | input | QW (4) | Multiplier; always unsigned |
| signed_mode | input | 1 | 0 = unsigned multiplicand, 1 = two's-complement multiplicand |
| product | output | MW+QW (9) | Product; in signed mode it is a two's-complement value |

## Verification
The bench builds the block at its default parameters: MW = 5 and QW = 4. At these widths all 32 × 16 operand pairs in both modes, 1024 cases in total, can be swept in full and compared with a product computed in the bench. The sweep covers the most negative multiplicand, every multiplier with its top bit set, and the carries that cross the full width of every row. Directed tasks check zero, unit and power-of-two multipliers and the sign of the result before the sweep runs.

// File: rtl/mularr_pkg.sv
// Package: shared mode encoding for the array multiplier.
// Assumes: nothing; holds type and helper definitions only.
package mularr_pkg;

    // Interpretation of the multiplicand operand.
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;

endpackage

// File: rtl/mularr_fa.sv
// Module: one full-adder cell, the unit from which each array row is tiled.
// Assumes: single-bit operands; purely combinational.
module mularr_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    // Sum and carry from the three input bits.
    always_comb begin
        half = a ^ b;
        s    = half ^ ci;
        co   = (a & b) | (ci & half);
    end
endmodule

// File: rtl/mularr_pp_gen.sv
// Module: forms one partial product by gating the multiplicand with a
// multiplier bit, then widens it to W bits with sign or zero fill.
// Assumes: W > MW; sgn selects sign fill (two's-complement multiplicand).
module mularr_pp_gen #(
    parameter int MW = 5,
    parameter int W  = 9
) (
    input  logic [MW-1:0] m,
    input  logic          qbit,
    input  logic          sgn,
    output logic [W-1:0]  addend
);
    localparam int FILL = W - MW;

    logic fill_bit;

    // Gate the multiplicand and extend it according to the mode.
    always_comb begin
        fill_bit = m[MW-1] & qbit & sgn;
        addend   = {{FILL{fill_bit}}, m & {MW{qbit}}};
    end

    // R4: a cleared multiplier bit contributes nothing to the sum
    always_comb begin
        if (!qbit) begin
            zero_pp_chk: assert (addend == '0)
                else $error("partial product non-zero with clear multiplier bit");
        end
    end
endmodule

// File: rtl/mularr_row_add.sv
// Module: one row of the array, a W-bit ripple adder built from full-adder
// cells that adds a partial product into the running sum.
// Assumes: carry-in of the row is zero; carry-out is reported separately.
module mularr_row_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] run_in,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;

    assign cy[0] = 1'b0;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_cell
            mularr_fa u_fa (
                .a  (run_in[b]),
                .b  (addend[b]),
                .ci (cy[b]),
                .s  (sum[b]),
                .co (cy[b+1])
            );
        end
    endgenerate

    assign cout = cy[W];

    // R1: the tiled cells agree with the arithmetic sum of the row
    always_comb begin
        row_sum_chk: assert ({cout, sum} == ({1'b0, run_in} + {1'b0, addend}))
            else $error("row adder result mismatch");
    end
endmodule

// File: rtl/mularr_top.sv
// Module: array multiplier. Row 0 is the first partial product; row i adds
// the partial product for multiplier bit i, aligned i places higher, into
// the bits of the running sum above position i.
// Assumes: QW >= 2; multiplier always unsigned; purely combinational.
module mularr_top #(
    parameter int MW = 5,
    parameter int QW = 4
) (
    input  logic [MW-1:0]    mul_a,
    input  logic [QW-1:0]    mul_b,
    input  logic             signed_mode,
    output logic [MW+QW-1:0] product
);
    import mularr_pkg::*;

    localparam int PW = MW + QW;

    logic            is_signed;
    logic [PW-1:0]   acc [QW];
    logic [QW-1:0]   row_cy;

    // Decode the mode pin.
    assign is_signed = (mul_mode_e'(signed_mode) == MODE_SIGNED);

    // Row 0: the first partial product spans the full product width.
    mularr_pp_gen #(.MW(MW), .W(PW)) u_pp0 (
        .m      (mul_a),
        .qbit   (mul_b[0]),
        .sgn    (is_signed),
        .addend (acc[0])
    );
    assign row_cy[0] = 1'b0;

    genvar i;
    generate
        for (i = 1; i < QW; i++) begin : g_row
            localparam int RW = PW - i;
            logic [RW-1:0] pp;
            logic [RW-1:0] hi_sum;

            mularr_pp_gen #(.MW(MW), .W(RW)) u_pp (
                .m      (mul_a),
                .qbit   (mul_b[i]),
                .sgn    (is_signed),
                .addend (pp)
            );

            mularr_row_add #(.W(RW)) u_add (
                .run_in (acc[i-1][PW-1:i]),
                .addend (pp),
                .sum    (hi_sum),
                .cout   (row_cy[i])
            );

            assign acc[i] = {hi_sum, acc[i-1][i-1:0]};
        end
    endgenerate

    assign product = acc[QW-1];

    // R4: zero multiplier gives zero product
    always_comb begin
        if (mul_b == '0) begin
            zero_q_chk: assert (product == '0)
                else $error("non-zero product with zero multiplier");
        end
    end

    // R5: unit multiplier passes the multiplicand through, extended
    always_comb begin
        if (mul_b == QW'(1)) begin
            unit_q_chk: assert (product ==
                    {{(PW-MW){mul_a[MW-1] & is_signed}}, mul_a})
                else $error("unit multiplier result wrong");
        end
    end

    // R7: sign of a signed-mode product follows the multiplicand
    always_comb begin
        if (is_signed) begin
            sign_chk: assert (product[PW-1] == (mul_a[MW-1] && (mul_b != '0)))
                else $error("signed product has wrong sign");
        end
    end

    // R8: unsigned mode never carries out of any row
    always_comb begin
        if (!is_signed) begin
            no_overflow_chk: assert (row_cy == '0)
                else $error("carry out of a row in unsigned mode");
        end
    end
endmodule

// File: tb/tb_mularr_top.sv
module tb_mularr_top;
    localparam int MW = 5;
    localparam int QW = 4;
    localparam int PW = MW + QW;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic [MW-1:0] mul_a = '0;
    logic [QW-1:0] mul_b = '0;
    logic          signed_mode = 1'b0;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mularr_top #(.MW(MW), .QW(QW)) dut (
        .mul_a       (mul_a),
        .mul_b       (mul_b),
        .signed_mode (signed_mode),
        .product     (product)
    );

    // Expected product from the requirements, using bench arithmetic.
    function automatic logic [PW-1:0] ref_prod(int m, int q, bit sgn);
        int mv;
        mv = m;
        if (sgn && m >= (1 << (MW-1))) mv = m - (1 << MW);
        return PW'(mv * q);
    endfunction

    task automatic apply(int m, int q, bit sgn);
        @(negedge clk);
        mul_a       = MW'(m);
        mul_b       = QW'(q);
        signed_mode = sgn;
        #1;
    endtask

    task automatic chk(string tag, int m, int q, bit sgn, logic [PW-1:0] exp);
        apply(m, q, sgn);
        checks++;
        if (product !== exp) begin
            errors++;
            $display("FAIL %s: m=%0d q=%0d sgn=%0d actual=%h expected=%h",
                     tag, m, q, sgn, product, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Idle inputs give a zero product (R4).
    task automatic t_idle();
        chk("R4 idle", 0, 0, 0, '0);
    endtask

    // Worked examples in both modes (R1, R2).
    task automatic t_examples();
        chk("R1 14x11", 14, 11, 0, PW'(154));
        chk("R2 -14x11", 32 - 14, 11, 1, 9'h166);
        chk("R2 15x11 signed", 15, 11, 1, PW'(165));
    endtask

    // Multiplier top bit is magnitude, not sign (R3).
    task automatic t_q_unsigned();
        chk("R3 1x15 signed", 1, 15, 1, PW'(15));
        chk("R3 -1x15 signed", 31, 15, 1, 9'h1F1);
        chk("R3 3x8 signed", 3, 8, 1, PW'(24));
    endtask

    // Zero multiplier in both modes (R4).
    task automatic t_zero_q();
        for (int m = 0; m < (1 << MW); m += 7) begin
            chk("R4 q=0 uns", m, 0, 0, '0);
            chk("R4 q=0 sgn", m, 0, 1, '0);
        end
    endtask

    // Unit multiplier extends the multiplicand (R5).
    task automatic t_unit();
        chk("R5 unit uns", 20, 1, 0, PW'(20));
        chk("R5 unit sgn", 20, 1, 1, {4'hF, 5'd20});
        chk("R5 unit sgn pos", 9, 1, 1, PW'(9));
    endtask

    // Power-of-two multipliers shift (R6).
    task automatic t_pow2();
        for (int k = 0; k < QW; k++) begin
            chk("R6 shift uns", 19, 1 << k, 0, PW'(19) << k);
            chk("R6 shift sgn", 19, 1 << k, 1, {{(PW-MW){1'b1}}, 5'd19} << k);
        end
    endtask

    // Sign bit of signed results (R7).
    task automatic t_sign();
        for (int m = 0; m < (1 << MW); m++) begin
            for (int q = 0; q < (1 << QW); q += 5) begin
                apply(m, q, 1);
                checks++;
                if (product[PW-1] !== ((m >= 16) && (q != 0))) begin
                    errors++;
                    $display("FAIL R7 sign: m=%0d q=%0d actual=%b expected=%b",
                             m, q, product[PW-1], (m >= 16) && (q != 0));
                end
            end
        end
    endtask

    // Extreme operands (R8).
    task automatic t_extremes();
        chk("R8 31x15", 31, 15, 0, PW'(465));
        chk("R8 -16x15", 16, 15, 1, 9'h110);
        chk("R8 15x15 sgn", 15, 15, 1, PW'(225));
    endtask

    // Full sweep against the bench reference (R1, R2).
    task automatic t_sweep(bit sgn);
        for (int m = 0; m < (1 << MW); m++) begin
            for (int q = 0; q < (1 << QW); q++) begin
                chk(sgn ? "R2 sweep" : "R1 sweep", m, q, sgn, ref_prod(m, q, sgn));
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        t_idle();
        t_examples();
        t_q_unsigned();
        t_zero_q();
        t_unit();
        t_pow2();
        t_sign();
        t_extremes();
        t_sweep(0);
        t_sweep(1);
        done = 1;
        finish_run();
    end
endmodule